// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock and Stall Guard

This block compares the motor's tachometer pulse period with a reference tick stream and hands a speed servo a signed error value. The reference tick is expected to run at the speed command frequency multiplied by the selected target count. At the commanded speed, one tachometer period therefore spans exactly that many ticks. Ticks are summed over two consecutive tachometer periods. The sum is compared with twice the target, and one result is issued per pair of periods. A positive error means the motor is slow and the drive should raise its on-duty. A negative error means it is fast and the drive should lower it.

An active-low in-lock flag reports when the measured pair lies within ±1/16 (6.25%) of the target. Every window limit is formed with shifts. A stall guard runs while the block is in the start state. It measures how long the in-lock flag has stayed high without a break, and when that reaches a set number of clock cycles it latches a trip, which the drive uses to switch off its high-side switches. Asserting stop sends the block to idle and clears everything. After stop is released, tachometer pulses are ignored for a fixed settling period.

Top module: `fg_speed_disc`

## Requirements
- R1: The target count N is `BASE_CNT << {~cnt_sel_b, ~cnt_sel_a}`. With BASE_CNT=64 the pin codes (a,b) give: 1,1 → 64; 0,1 → 128; 1,0 → 256; 0,0 → 512. A tachometer period of exactly N ticks gives an error of 0.
- R2: After settling, the first tachometer pulse arms the measurement. After that, a result (`err_vld` high for one cycle) is issued on every second pulse and never on the pulses in between. It appears two clock edges after the pulse is sampled.
- R3: `speed_err` equals the ticks counted over the two periods minus 2N, as a two's-complement value. A tick that coincides with a closing pulse counts toward the period that pulse closes.
- R4: Once enabled (R5), `lock_n` goes low after a result whose tick sum lies within 2N ± (2N>>4), bounds included. It goes high after a result outside that range, and it holds its value between results.
- R5: `lock_n` stays high on the first result after start. It can go low only from the second result on.
- R6: If the tick count of the window reaches 4N before the window closes, a result is issued with a tick sum of 4N (error +2N, lock lost), and a new window starts.
- R7: In the start state, if `lock_n` stays high for PROT_CYC consecutive cycles, `prot_trip` goes high. It then stays high, even if lock is regained, until stop is asserted.
- R8: A low `lock_n` clears the stall timer, so a motor that locks before the timeout and stays locked never trips.
- R9: While `stop` is high, `err_vld` and `speed_err` stay 0, `lock_n` stays 1, `prot_trip` stays 0, and tachometer pulses have no effect.
- R10: For SETTLE_CYC cycles after stop is released, tachometer pulses are ignored. Measurement arms on the first pulse after that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_pulse | input | 1 | One-cycle pulse per tachometer period, already synchronised |
| ref_tick | input | 1 | Reference tick enable, one count per high cycle |
| cnt_sel_a | input | 1 | Target count select, low bit inverted |
| cnt_sel_b | input | 1 | Target count select, high bit inverted |
| stop | input | 1 | 1 = stop (idle), 0 = start |
| speed_err | output | CNT_W+1 | Signed speed error, positive = slow |
| err_vld | output | 1 | One-cycle strobe for a new error |
| lock_n | output | 1 | Low while speed is inside the lock window |
| prot_trip | output | 1 | Latched stall protection trip |

## Verification
The bench builds the block with BASE_CNT=64, SETTLE_CYC=32 and PROT_CYC=2000. With these values all four target counts, including 512, can be reached in a few thousand cycles. A stall trip occurs well within the run, while a motor running at 64 ticks per period locks long before the timeout. Ticks arrive on every second clock, so a pulse spacing of 2P clocks gives exactly P ticks. This makes the exact window edges of 120 and 136 ticks, and the sums just outside them, easy to produce. Running without pulses after arming reaches the 4N saturation limit in 512 cycles.

// File: rtl/fg_sd_pkg.sv
package fg_sd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_t;

  // Shift applied to the base count; the select pins are active low.
  function automatic logic [1:0] sel_shift(input logic sel_a, input logic sel_b);
    return {~sel_b, ~sel_a};
  endfunction

endpackage

// File: rtl/fg_sd_settle_guard.sv
module fg_sd_settle_guard #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  output logic run,
  output logic ready
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          run_d, ready_d;

  always_comb begin
    run_d   = ~stop;
    cnt_d   = cnt_q;
    ready_d = ready;
    if (stop) begin
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (!ready) begin
      if (cnt_q == SW'(SETTLE_CYC - 1)) ready_d = 1'b1;
      else                              cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run   <= 1'b0;
      ready <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run   <= run_d;
      ready <= ready_d;
    end
  end

  a_r9_stop_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !ready);
  a_r10_ready_within_run: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> run);

endmodule

// File: rtl/fg_sd_period_acc.sv
module fg_sd_period_acc
  import fg_sd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic             fg_pulse,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] lim,
  output logic             done,
  output logic [CNT_W-1:0] total
);
  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] acc_q, acc_d;
  logic [CNT_W:0]   acc_inc;
  logic             sat_hit;
  logic             done_d;
  logic [CNT_W-1:0] total_d;

  assign acc_inc = {1'b0, acc_q} + {{CNT_W{1'b0}}, ref_tick};
  assign sat_hit = (phase_q != PH_IDLE) && (acc_inc >= {1'b0, lim});

  always_comb begin
    phase_d = phase_q;
    acc_d   = acc_q;
    done_d  = 1'b0;
    total_d = total;
    if (!ready) begin
      phase_d = PH_IDLE;
      acc_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (fg_pulse) begin
            phase_d = PH_FIRST;
            acc_d   = '0;
          end
        end
        PH_FIRST: begin
          if (sat_hit) begin
            done_d  = 1'b1;
            total_d = lim;
            acc_d   = '0;
          end else if (fg_pulse) begin
            phase_d = PH_SECOND;
            acc_d   = acc_inc[CNT_W-1:0];
          end else begin
            acc_d   = acc_inc[CNT_W-1:0];
          end
        end
        PH_SECOND: begin
          if (sat_hit) begin
            done_d  = 1'b1;
            total_d = lim;
            phase_d = PH_FIRST;
            acc_d   = '0;
          end else if (fg_pulse) begin
            done_d  = 1'b1;
            total_d = acc_inc[CNT_W-1:0];
            phase_d = PH_FIRST;
            acc_d   = '0;
          end else begin
            acc_d   = acc_inc[CNT_W-1:0];
          end
        end
        default: begin
          phase_d = PH_IDLE;
          acc_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      acc_q   <= '0;
      done    <= 1'b0;
      total   <= '0;
    end else begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
      done    <= done_d;
      total   <= total_d;
    end
  end

  a_r6_total_capped: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (total <= lim));
  a_r2_idle_never_done: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |=> !done);
  a_r10_unready_never_done: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !done);

endmodule

// File: rtl/fg_sd_judge.sv
module fg_sd_judge #(
  parameter int CNT_W = 12,
  parameter int ERR_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ready,
  input  logic                    done,
  input  logic [CNT_W-1:0]        total,
  input  logic [CNT_W-1:0]        tgt2,
  output logic signed [ERR_W-1:0] err,
  output logic                    err_vld,
  output logic                    lock_n
);
  logic [CNT_W-1:0]        margin, win_lo, win_hi;
  logic                    in_win;
  logic signed [ERR_W-1:0] diff;
  logic signed [ERR_W-1:0] err_d;
  logic                    vld_d, inlock_q, inlock_d;
  logic [1:0]              seen_q, seen_d;

  assign margin = tgt2 >> 4;
  assign win_lo = tgt2 - margin;
  assign win_hi = tgt2 + margin;
  assign in_win = (total >= win_lo) && (total <= win_hi);
  assign diff   = $signed({1'b0, total}) - $signed({1'b0, tgt2});

  always_comb begin
    err_d    = err;
    vld_d    = 1'b0;
    inlock_d = inlock_q;
    seen_d   = seen_q;
    if (!ready) begin
      err_d    = '0;
      inlock_d = 1'b0;
      seen_d   = 2'd0;
    end else if (done) begin
      vld_d    = 1'b1;
      err_d    = diff;
      inlock_d = in_win;
      if (seen_q != 2'd2) seen_d = seen_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err      <= '0;
      err_vld  <= 1'b0;
      inlock_q <= 1'b0;
      seen_q   <= 2'd0;
    end else begin
      err      <= err_d;
      err_vld  <= vld_d;
      inlock_q <= inlock_d;
      seen_q   <= seen_d;
    end
  end

  assign lock_n = ~(inlock_q && (seen_q == 2'd2));

  a_r4_lock_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(done && in_win));
  a_r5_first_result_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ready && seen_q == 2'd0) |=> lock_n);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (!err_vld && lock_n));

endmodule

// File: rtl/fg_sd_prot_timer.sv
module fg_sd_prot_timer #(
  parameter int PROT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic lock_n,
  output logic trip
);
  localparam int PW = $clog2(PROT_CYC + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          trip_d;

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip;
    if (!run) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else if (!trip) begin
      if (!lock_n)                        cnt_d  = '0;
      else if (cnt_q == PW'(PROT_CYC - 1)) trip_d = 1'b1;
      else                                cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      trip  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      trip  <= trip_d;
    end
  end

  a_r7_trip_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (run && trip) |=> trip);
  a_r8_trip_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(lock_n));
  a_r9_stop_clears_trip: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !trip);

endmodule

// File: rtl/fg_speed_disc.sv
module fg_speed_disc
  import fg_sd_pkg::*;
#(
  parameter int BASE_CNT   = 64,
  parameter int SETTLE_CYC = 1024,
  parameter int PROT_CYC   = 1000000,
  localparam int NMAX      = BASE_CNT * 8,
  localparam int CNT_W     = $clog2(4 * NMAX + 1),
  localparam int ERR_W     = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fg_pulse,
  input  logic                    ref_tick,
  input  logic                    cnt_sel_a,
  input  logic                    cnt_sel_b,
  input  logic                    stop,
  output logic signed [ERR_W-1:0] speed_err,
  output logic                    err_vld,
  output logic                    lock_n,
  output logic                    prot_trip
);
  logic [1:0]       shamt;
  logic [CNT_W-1:0] tgt, tgt2, lim;
  logic             run, ready, done;
  logic [CNT_W-1:0] total;

  assign shamt = sel_shift(cnt_sel_a, cnt_sel_b);
  assign tgt   = CNT_W'(BASE_CNT) << shamt;
  assign tgt2  = tgt << 1;
  assign lim   = tgt << 2;

  fg_sd_settle_guard #(.SETTLE_CYC(SETTLE_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .stop(stop), .run(run), .ready(ready)
  );

  fg_sd_period_acc #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .ready(ready), .fg_pulse(fg_pulse),
    .ref_tick(ref_tick), .lim(lim), .done(done), .total(total)
  );

  fg_sd_judge #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .total(total),
    .tgt2(tgt2), .err(speed_err), .err_vld(err_vld), .lock_n(lock_n)
  );

  fg_sd_prot_timer #(.PROT_CYC(PROT_CYC)) u_prot (
    .clk(clk), .rst_n(rst_n), .run(run), .lock_n(lock_n), .trip(prot_trip)
  );

endmodule

// File: tb/sim_fg_speed_disc.sv
module sim_fg_speed_disc;
  localparam int SETTLE = 32;
  localparam int PROT   = 2000;

  logic clk = 1'b0;
  logic rst_n, fg_pulse, ref_tick, sel_a, sel_b, stop;
  logic signed [12:0] speed_err;
  logic err_vld, lock_n, prot_trip;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fg_speed_disc #(.BASE_CNT(64), .SETTLE_CYC(SETTLE), .PROT_CYC(PROT)) u0 (
    .clk(clk), .rst_n(rst_n), .fg_pulse(fg_pulse), .ref_tick(ref_tick),
    .cnt_sel_a(sel_a), .cnt_sel_b(sel_b), .stop(stop),
    .speed_err(speed_err), .err_vld(err_vld), .lock_n(lock_n), .prot_trip(prot_trip)
  );

  // Tick on every second clock: a gap of 2P clocks holds exactly P ticks.
  always @(negedge clk) begin
    if (!rst_n) ref_tick <= 1'b0;
    else        ref_tick <= ~ref_tick;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One pulse 'gap' clocks after the previous one; outputs sampled two edges later.
  task automatic fg_shot(input int gap, output int v, output int e, output int l);
    repeat (gap - 2) @(negedge clk);
    fg_pulse = 1'b1;
    @(negedge clk);
    fg_pulse = 1'b0;
    @(negedge clk);
    v = int'(err_vld);
    e = int'(speed_err);
    l = int'(lock_n);
  endtask

  task automatic restart(input bit a, input bit b);
    int v, e, l;
    stop = 1'b1;
    sel_a = a;
    sel_b = b;
    repeat (3) @(negedge clk);
    fg_shot(4, v, e, l);
    chk("R9", "vld while stopped", v, 0);
    chk("R9", "lock_n while stopped", l, 1);
    chk("R9", "trip while stopped", int'(prot_trip), 0);
    stop = 1'b0;
    repeat (SETTLE + 5) @(negedge clk);
  endtask

  // Two periods of p1, p2 ticks; checks the result strobe pattern.
  task automatic pair(input int p1, input int p2, input string req,
                      output int e, output int l);
    int v;
    fg_shot(2 * p1, v, e, l);
    chk("R2", "vld mid-pair", v, 0);
    fg_shot(2 * p2, v, e, l);
    chk(req, "vld at pair end", v, 1);
  endtask

  task automatic t_select(input bit a, input bit b, input int n);
    int v, e, l;
    restart(a, b);
    fg_shot(4, v, e, l);
    chk("R2", "vld at arm", v, 0);
    pair(n, n, "R2", e, l);
    chk("R1", "err first result", e, 0);
    chk("R5", "lock_n first result", l, 1);
    pair(n, n, "R2", e, l);
    chk("R1", "err second result", e, 0);
    chk("R4", "lock_n second result", l, 0);
  endtask

  task automatic t_window();
    int v, e, l;
    restart(1'b1, 1'b1);
    fg_shot(4, v, e, l);
    pair(64, 64, "R2", e, l);
    pair(64, 64, "R2", e, l);
    pair(68, 68, "R3", e, l);
    chk("R3", "err sum 136", e, 8);
    chk("R4", "lock_n upper bound", l, 0);
    pair(68, 69, "R3", e, l);
    chk("R3", "err sum 137", e, 9);
    chk("R4", "lock_n above window", l, 1);
    pair(60, 60, "R3", e, l);
    chk("R3", "err sum 120", e, -8);
    chk("R4", "lock_n lower bound", l, 0);
    pair(59, 60, "R3", e, l);
    chk("R3", "err sum 119", e, -9);
    chk("R4", "lock_n below window", l, 1);
    pair(90, 90, "R3", e, l);
    chk("R3", "err slow", e, 52);
  endtask

  task automatic t_settle();
    int v, e, l;
    stop = 1'b1;
    sel_a = 1'b1;
    sel_b = 1'b1;
    repeat (4) @(negedge clk);
    stop = 1'b0;
    for (int i = 0; i < 3; i++) begin
      fg_shot(6, v, e, l);
      chk("R10", "vld during settle", v, 0);
    end
    repeat (SETTLE) @(negedge clk);
    fg_shot(4, v, e, l);
    chk("R10", "vld at arm", v, 0);
    fg_shot(128, v, e, l);
    chk("R10", "vld at second pulse", v, 0);
    fg_shot(128, v, e, l);
    chk("R10", "vld at third pulse", v, 1);
    chk("R10", "err after settle", e, 0);
  endtask

  task automatic t_saturate();
    int v, e, l;
    bit seen;
    restart(1'b1, 1'b1);
    fg_shot(4, v, e, l);
    seen = 1'b0;
    for (int i = 0; i < 8 * 64 + 40 && !seen; i++) begin
      @(negedge clk);
      if (err_vld) begin
        seen = 1'b1;
        chk("R6", "saturated err", int'(speed_err), 128);
        chk("R6", "lock_n saturated", int'(lock_n), 1);
      end
    end
    chk("R6", "saturation result seen", int'(seen), 1);
  endtask

  task automatic t_trip();
    int v, e, l;
    restart(1'b1, 1'b1);
    repeat (PROT - SETTLE - 30) @(negedge clk);
    chk("R7", "trip before timeout", int'(prot_trip), 0);
    repeat (50) @(negedge clk);
    chk("R7", "trip after timeout", int'(prot_trip), 1);
    fg_shot(4, v, e, l);
    pair(64, 64, "R2", e, l);
    pair(64, 64, "R2", e, l);
    chk("R4", "lock regained", l, 0);
    chk("R7", "trip latched while locked", int'(prot_trip), 1);
    stop = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "stop clears trip", int'(prot_trip), 0);
  endtask

  task automatic t_no_trip();
    int v, e, l;
    restart(1'b1, 1'b1);
    fg_shot(4, v, e, l);
    for (int i = 0; i < 30; i++) fg_shot(128, v, e, l);
    chk("R8", "locked long run lock_n", l, 0);
    chk("R8", "no trip when locked", int'(prot_trip), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    fg_pulse = 1'b0;
    stop = 1'b1;
    sel_a = 1'b1;
    sel_b = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset lock_n", int'(lock_n), 1);
    chk("R9", "reset trip", int'(prot_trip), 0);
    chk("R9", "reset vld", int'(err_vld), 0);
    chk("R9", "reset err", int'(speed_err), 0);
    t_select(1'b1, 1'b1, 64);
    t_select(1'b0, 1'b1, 128);
    t_select(1'b1, 1'b0, 256);
    t_select(1'b0, 1'b0, 512);
    t_window();
    t_settle();
    t_saturate();
    t_trip();
    t_no_trip();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule